// File: doc/BRIEF.md
# Set-Associative Address Translation Cache

This block turns a 64-bit virtual address into a 32-bit physical address by looking it up in a small set-associative cache of page table entries. Pages are 4 KB, so the low 12 address bits pass through unchanged. The remaining 52-bit virtual page number is split in two. Its low bits pick a set, and its upper bits are compared as a tag against every way of that set. The lookup also checks an address-space ID. A per-way one-hot match then drives an AND-OR way multiplexer, which selects the stored entry.

Each stored entry carries a present flag, a dirty flag, a two-bit rights code and a 20-bit frame number. A lookup that finds the entry returns exactly one of four outcomes: the translation, a page fault (the entry is not present), or a protection fault (the access kind is not allowed). If no entry matches, the outcome is a miss.

The surrounding logic controls the cache through three operations:
- A refill port installs entries that were walked elsewhere.
- A single-entry invalidate removes a page that has been swapped out.
- A full flush clears the whole cache.

Entries are tagged with an address-space ID, so a context switch does not need a flush.

Top module: `xlat_cache`

## Requirements
- R1: After a synchronous active-low reset no entry is held: `rsp_vld` and every outcome flag are low, and any lookup reports a miss.
- R2: A request sampled on a clock edge produces `rsp_vld` high on the next cycle with exactly one of `rsp_hit`, `rsp_miss`, `rsp_pgflt`, `rsp_prot` high. Without a request, `rsp_vld` and all flags are low.
- R3: On a hit, `rsp_pa` is the stored frame number concatenated with `req_va[11:0]`. On any other outcome, `rsp_pa` and `rsp_dirty` are zero.
- R4: The set index is `va[16:12]` and the tag is `va[63:17]`. Entries that differ in any tag bit or in the set index are distinct. Four entries can coexist in one set.
- R5: A refill whose page and ID already match an entry in its set overwrites that way and leaves the replacement pointer alone. Any other refill writes the way named by that set's round-robin pointer, which starts at way 0 after reset or flush and then advances by one with wrap-around.
- R6: A lookup that matches an entry whose present flag is 0 reports `rsp_pgflt`.
- R7: Rights codes on `fill_rgt`:
  - 0: read only
  - 1: read/write
  - 2: read/execute
  - 3: read/write/execute

  Access kinds on `req_kind`:
  - 0: read
  - 1: write
  - 2: execute
  - 3: treated as read

  A write to an entry whose rights code has bit 0 clear, or an execute to an entry whose rights code has bit 1 clear, reports `rsp_prot`. The outcome priority is miss, then page fault, then protection fault.
- R8: A write that hits sets the entry's dirty flag. `rsp_dirty` reports the flag as it stands after the access. A faulted write leaves the flag unchanged.
- R9: An invalidate clears only the entry that matches its page number and ID. Other entries in the same set stay usable.
- R10: A flush removes every entry.
- R11: An entry matches only a request that carries the same `asid`. The same page can be cached under two IDs at once.
- R12: A lookup made in the same cycle as a refill, invalidate or flush sees the contents from before that update. When more than one update is requested in a cycle, flush overrides invalidate, and invalidate overrides refill.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_vld | input | 1 | Lookup request |
| req_va | input | 64 | Virtual address to translate |
| req_kind | input | 2 | Access kind (0 read, 1 write, 2 execute) |
| req_asid | input | 8 | Address-space ID of the request |
| fill_en | input | 1 | Install an entry |
| fill_vpn | input | 52 | Virtual page number of the new entry |
| fill_asid | input | 8 | Address-space ID of the new entry |
| fill_prs | input | 1 | Present flag of the new entry |
| fill_drt | input | 1 | Initial dirty flag of the new entry |
| fill_rgt | input | 2 | Rights code of the new entry |
| fill_frm | input | 20 | Physical frame number of the new entry |
| inv_en | input | 1 | Invalidate one entry |
| inv_vpn | input | 52 | Virtual page number to invalidate |
| inv_asid | input | 8 | Address-space ID to invalidate |
| flush_all | input | 1 | Remove all entries |
| rsp_vld | output | 1 | Response present (one cycle after request) |
| rsp_hit | output | 1 | Translation delivered |
| rsp_miss | output | 1 | No matching entry |
| rsp_pgflt | output | 1 | Matching entry is not present |
| rsp_prot | output | 1 | Access kind not permitted |
| rsp_dirty | output | 1 | Dirty flag of the hit entry after the access |
| rsp_pa | output | 32 | Physical address on a hit |

## Verification
Most internal faults surface on the first lookup that touches the damaged state, and always one cycle after that lookup. Examples are a stored field, a corrupted tag compare, or a misrouted way select. They show up as a wrong outcome flag or a wrong frame in `rsp_pa`. A replacement pointer that advances wrongly stays hidden until a set overflows. It is exposed when the fifth or sixth refill into that set evicts a different page than the round-robin order predicts. A lost dirty update shows only on a later hit to the same page, through `rsp_dirty`. Invalidate and ID faults show as a surviving page, or as a neighbour in the same set that has wrongly vanished.

// File: rtl/xlat_pkg.sv
// Package xlat_pkg
// Shared encodings for the translation cache: access kinds, rights codes,
// lookup outcomes and the rights check. Assumes a two-bit kind and rights code.
package xlat_pkg;

    localparam logic [1:0] ACC_RD = 2'd0;
    localparam logic [1:0] ACC_WR = 2'd1;
    localparam logic [1:0] ACC_EX = 2'd2;

    localparam logic [1:0] RGT_RO  = 2'd0;
    localparam logic [1:0] RGT_RW  = 2'd1;
    localparam logic [1:0] RGT_RX  = 2'd2;
    localparam logic [1:0] RGT_RWX = 2'd3;

    typedef enum logic [1:0] {
        OUT_MISS  = 2'd0,
        OUT_HIT   = 2'd1,
        OUT_PGFLT = 2'd2,
        OUT_PROT  = 2'd3
    } outcome_e;

    // Rights bit 0 grants write, bit 1 grants execute; reads are always allowed.
    function automatic logic rights_ok(input logic [1:0] rgt, input logic [1:0] acc);
        case (acc)
            ACC_WR:  return rgt[0];
            ACC_EX:  return rgt[1];
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/xlat_store.sv
// Module xlat_store
// Flop array holding every entry of the translation cache, SETS x WAYS.
// Exposes all entries for combinational reads. Update priority within one
// cycle: flush over invalidate over refill over dirty marking.
// Assumes at most one refill, one invalidate and one dirty mark per cycle.
module xlat_store #(
    parameter int SETS   = 32,
    parameter int WAYS   = 4,
    parameter int TAG_W  = 47,
    parameter int ASID_W = 8,
    parameter int FRM_W  = 20,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              mark_en,
    input  logic [SET_W-1:0]  mark_set,
    input  logic [WAYS-1:0]   mark_hit,
    input  logic              fill_en,
    input  logic [SET_W-1:0]  fill_set,
    input  logic [WAY_W-1:0]  fill_way,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic              fill_prs,
    input  logic              fill_drt,
    input  logic [1:0]        fill_rgt,
    input  logic [FRM_W-1:0]  fill_frm,
    input  logic              inv_en,
    input  logic [SET_W-1:0]  inv_set,
    input  logic [WAYS-1:0]   inv_hit,
    output logic              occ_o  [SETS][WAYS],
    output logic [TAG_W-1:0]  tag_o  [SETS][WAYS],
    output logic [ASID_W-1:0] asid_o [SETS][WAYS],
    output logic              prs_o  [SETS][WAYS],
    output logic              drt_o  [SETS][WAYS],
    output logic [1:0]        rgt_o  [SETS][WAYS],
    output logic [FRM_W-1:0]  frm_o  [SETS][WAYS]
);

    // Entry occupancy: cleared by reset, flush and invalidate; set by refill.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    occ_o[s][w] <= 1'b0;
        end else begin
            if (fill_en)
                occ_o[fill_set][fill_way] <= 1'b1;
            if (inv_en)
                for (int w = 0; w < WAYS; w++)
                    if (inv_hit[w])
                        occ_o[inv_set][w] <= 1'b0;
        end
    end

    // Entry payload: written by refill; dirty flag also set by write hits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++) begin
                    tag_o[s][w]  <= '0;
                    asid_o[s][w] <= '0;
                    prs_o[s][w]  <= 1'b0;
                    drt_o[s][w]  <= 1'b0;
                    rgt_o[s][w]  <= '0;
                    frm_o[s][w]  <= '0;
                end
        end else if (!flush) begin
            if (mark_en)
                for (int w = 0; w < WAYS; w++)
                    if (mark_hit[w])
                        drt_o[mark_set][w] <= 1'b1;
            if (fill_en) begin
                tag_o[fill_set][fill_way]  <= fill_tag;
                asid_o[fill_set][fill_way] <= fill_asid;
                prs_o[fill_set][fill_way]  <= fill_prs;
                drt_o[fill_set][fill_way]  <= fill_drt;
                rgt_o[fill_set][fill_way]  <= fill_rgt;
                frm_o[fill_set][fill_way]  <= fill_frm;
            end
        end
    end

endmodule

// File: rtl/xlat_rr.sv
// Module xlat_rr
// Per-set round-robin victim pointers. Each pointer starts at way 0 after
// reset or flush and steps by one, wrapping at WAYS, when its set takes a
// refill that did not reuse a matching way.
module xlat_rr #(
    parameter int SETS   = 32,
    parameter int WAYS   = 4,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             adv_en,
    input  logic [SET_W-1:0] adv_set,
    input  logic [SET_W-1:0] qry_set,
    output logic [WAY_W-1:0] ptr_o
);

    localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(WAYS - 1);

    logic [WAY_W-1:0] ptr_q [SETS];

    // Pointer update: clear on reset/flush, advance on an allocating refill.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            for (int s = 0; s < SETS; s++)
                ptr_q[s] <= '0;
        end else if (adv_en) begin
            ptr_q[adv_set] <= (ptr_q[adv_set] == LAST_WAY) ? '0 : ptr_q[adv_set] + 1'b1;
        end
    end

    // Victim readout for the set being refilled.
    assign ptr_o = ptr_q[qry_set];

endmodule

// File: rtl/xlat_match.sv
// Module xlat_match
// Parallel tag compare over the ways of one set. A way matches when it is
// occupied, its tag equals the key and, when USE_ASID is set, its ID equals
// the key ID. Assumes at most one way matches (refill reuses matching ways).
module xlat_match #(
    parameter int WAYS     = 4,
    parameter int TAG_W    = 47,
    parameter int ASID_W   = 8,
    parameter bit USE_ASID = 1'b1
) (
    input  logic              occ      [WAYS],
    input  logic [TAG_W-1:0]  tag      [WAYS],
    input  logic [ASID_W-1:0] asid     [WAYS],
    input  logic [TAG_W-1:0]  key_tag,
    input  logic [ASID_W-1:0] key_asid,
    output logic [WAYS-1:0]   hit_vec
);

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        if (USE_ASID) begin : g_id
            // Compare tag and address-space ID of one way.
            assign hit_vec[w] = occ[w] && (tag[w] == key_tag) && (asid[w] == key_asid);
        end else begin : g_noid
            // Compare tag only; IDs are not stored meaningfully.
            assign hit_vec[w] = occ[w] && (tag[w] == key_tag);
        end
    end

endmodule

// File: rtl/xlat_cache.sv
// Module xlat_cache
// Set-associative translation cache with rights checking. A lookup is
// decoded, matched and checked in one cycle and registered, so results
// appear the cycle after the request. Refill, invalidate and flush update
// the array at the same edge; a lookup in that cycle sees prior contents.
// Assumes PG_OFS-bit page offset, power-of-two SETS and WAYS >= 2.
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int VA_W     = 64,
    parameter int PA_W     = 32,
    parameter int PG_OFS   = 12,
    parameter int SETS     = 32,
    parameter int WAYS     = 4,
    parameter int ASID_W   = 8,
    parameter bit USE_ASID = 1'b1,
    localparam int VPN_W   = VA_W - PG_OFS,
    localparam int FRM_W   = PA_W - PG_OFS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_vld,
    input  logic [VA_W-1:0]   req_va,
    input  logic [1:0]        req_kind,
    input  logic [ASID_W-1:0] req_asid,
    input  logic              fill_en,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic              fill_prs,
    input  logic              fill_drt,
    input  logic [1:0]        fill_rgt,
    input  logic [FRM_W-1:0]  fill_frm,
    input  logic              inv_en,
    input  logic [VPN_W-1:0]  inv_vpn,
    input  logic [ASID_W-1:0] inv_asid,
    input  logic              flush_all,
    output logic              rsp_vld,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              rsp_pgflt,
    output logic              rsp_prot,
    output logic              rsp_dirty,
    output logic [PA_W-1:0]   rsp_pa
);

    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int TAG_W = VPN_W - SET_W;

    // ---------------- address decode ----------------
    logic [SET_W-1:0] lk_set, fl_set, iv_set;
    logic [TAG_W-1:0] lk_key, fl_key, iv_key;

    assign lk_set = req_va[PG_OFS +: SET_W];
    assign lk_key = req_va[VA_W-1 -: TAG_W];
    assign fl_set = fill_vpn[SET_W-1:0];
    assign fl_key = fill_vpn[VPN_W-1 -: TAG_W];
    assign iv_set = inv_vpn[SET_W-1:0];
    assign iv_key = inv_vpn[VPN_W-1 -: TAG_W];

    // ---------------- storage ----------------
    logic              st_occ  [SETS][WAYS];
    logic [TAG_W-1:0]  st_tag  [SETS][WAYS];
    logic [ASID_W-1:0] st_asid [SETS][WAYS];
    logic              st_prs  [SETS][WAYS];
    logic              st_drt  [SETS][WAYS];
    logic [1:0]        st_rgt  [SETS][WAYS];
    logic [FRM_W-1:0]  st_frm  [SETS][WAYS];

    logic [WAYS-1:0]  lk_hit, fl_hit, iv_hit;
    logic [WAY_W-1:0] fl_way, fl_match_way, rr_way;
    logic             fl_reuse;
    logic             mark_en;

    xlat_store #(
        .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .ASID_W(ASID_W), .FRM_W(FRM_W)
    ) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush_all),
        .mark_en   (mark_en),
        .mark_set  (lk_set),
        .mark_hit  (lk_hit),
        .fill_en   (fill_en),
        .fill_set  (fl_set),
        .fill_way  (fl_way),
        .fill_tag  (fl_key),
        .fill_asid (fill_asid),
        .fill_prs  (fill_prs),
        .fill_drt  (fill_drt),
        .fill_rgt  (fill_rgt),
        .fill_frm  (fill_frm),
        .inv_en    (inv_en),
        .inv_set   (iv_set),
        .inv_hit   (iv_hit),
        .occ_o     (st_occ),
        .tag_o     (st_tag),
        .asid_o    (st_asid),
        .prs_o     (st_prs),
        .drt_o     (st_drt),
        .rgt_o     (st_rgt),
        .frm_o     (st_frm)
    );

    // ---------------- set row extraction ----------------
    logic              lk_occ [WAYS], fl_occ [WAYS], iv_occ [WAYS];
    logic [TAG_W-1:0]  lk_tag [WAYS], fl_tag [WAYS], iv_tag [WAYS];
    logic [ASID_W-1:0] lk_ids [WAYS], fl_ids [WAYS], iv_ids [WAYS];

    // Pull the addressed set's compare fields for each of the three ports.
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            lk_occ[w] = st_occ[lk_set][w];
            lk_tag[w] = st_tag[lk_set][w];
            lk_ids[w] = st_asid[lk_set][w];
            fl_occ[w] = st_occ[fl_set][w];
            fl_tag[w] = st_tag[fl_set][w];
            fl_ids[w] = st_asid[fl_set][w];
            iv_occ[w] = st_occ[iv_set][w];
            iv_tag[w] = st_tag[iv_set][w];
            iv_ids[w] = st_asid[iv_set][w];
        end
    end

    xlat_match #(.WAYS(WAYS), .TAG_W(TAG_W), .ASID_W(ASID_W), .USE_ASID(USE_ASID)) lk_match_i (
        .occ(lk_occ), .tag(lk_tag), .asid(lk_ids),
        .key_tag(lk_key), .key_asid(req_asid), .hit_vec(lk_hit)
    );

    xlat_match #(.WAYS(WAYS), .TAG_W(TAG_W), .ASID_W(ASID_W), .USE_ASID(USE_ASID)) fl_match_i (
        .occ(fl_occ), .tag(fl_tag), .asid(fl_ids),
        .key_tag(fl_key), .key_asid(fill_asid), .hit_vec(fl_hit)
    );

    xlat_match #(.WAYS(WAYS), .TAG_W(TAG_W), .ASID_W(ASID_W), .USE_ASID(USE_ASID)) iv_match_i (
        .occ(iv_occ), .tag(iv_tag), .asid(iv_ids),
        .key_tag(iv_key), .key_asid(inv_asid), .hit_vec(iv_hit)
    );

    // ---------------- refill way choice ----------------
    xlat_rr #(.SETS(SETS), .WAYS(WAYS)) rr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush_all),
        .adv_en  (fill_en && !fl_reuse),
        .adv_set (fl_set),
        .qry_set (fl_set),
        .ptr_o   (rr_way)
    );

    // Encode the matching way of the refill set, if any.
    always_comb begin
        fl_match_way = '0;
        for (int w = 0; w < WAYS; w++)
            if (fl_hit[w])
                fl_match_way = WAY_W'(w);
    end

    assign fl_reuse = |fl_hit;
    assign fl_way   = fl_reuse ? fl_match_way : rr_way;

    // ---------------- way multiplexer and checks ----------------
    logic             sel_prs, sel_drt;
    logic [1:0]       sel_rgt;
    logic [FRM_W-1:0] sel_frm;
    outcome_e         outc;
    logic             is_write;

    // AND-OR select of the matching way's payload.
    always_comb begin
        sel_prs = 1'b0;
        sel_drt = 1'b0;
        sel_rgt = '0;
        sel_frm = '0;
        for (int w = 0; w < WAYS; w++)
            if (lk_hit[w]) begin
                sel_prs = sel_prs | st_prs[lk_set][w];
                sel_drt = sel_drt | st_drt[lk_set][w];
                sel_rgt = sel_rgt | st_rgt[lk_set][w];
                sel_frm = sel_frm | st_frm[lk_set][w];
            end
    end

    // Outcome priority: miss, then not present, then rights violation.
    always_comb begin
        if (!(|lk_hit))
            outc = OUT_MISS;
        else if (!sel_prs)
            outc = OUT_PGFLT;
        else if (!rights_ok(sel_rgt, req_kind))
            outc = OUT_PROT;
        else
            outc = OUT_HIT;
    end

    assign is_write = (req_kind == ACC_WR);
    assign mark_en  = req_vld && (outc == OUT_HIT) && is_write;

    // ---------------- response register ----------------
    // Capture the lookup result for presentation one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_vld   <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_pgflt <= 1'b0;
            rsp_prot  <= 1'b0;
            rsp_dirty <= 1'b0;
            rsp_pa    <= '0;
        end else begin
            rsp_vld   <= req_vld;
            rsp_hit   <= req_vld && (outc == OUT_HIT);
            rsp_miss  <= req_vld && (outc == OUT_MISS);
            rsp_pgflt <= req_vld && (outc == OUT_PGFLT);
            rsp_prot  <= req_vld && (outc == OUT_PROT);
            rsp_dirty <= req_vld && (outc == OUT_HIT) && (sel_drt || is_write);
            rsp_pa    <= (req_vld && (outc == OUT_HIT)) ? {sel_frm, req_va[PG_OFS-1:0]} : '0;
        end
    end

endmodule

// File: rtl/xlat_cache_chk.sv
// Module xlat_cache_chk
// Port-level properties of the translation cache, bound to every instance.
// Assumes the one-cycle registered response of xlat_cache.
module xlat_cache_chk #(
    parameter int VA_W   = 64,
    parameter int PA_W   = 32,
    parameter int PG_OFS = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_vld,
    input logic [VA_W-1:0] req_va,
    input logic [1:0]      req_kind,
    input logic            flush_all,
    input logic            rsp_vld,
    input logic            rsp_hit,
    input logic            rsp_miss,
    input logic            rsp_pgflt,
    input logic            rsp_prot,
    input logic            rsp_dirty,
    input logic [PA_W-1:0] rsp_pa
);

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n) req_vld |=> rsp_vld); // R2
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n) !req_vld |=> !rsp_vld); // R2
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n) rsp_vld |-> $countones({rsp_hit, rsp_miss, rsp_pgflt, rsp_prot}) == 1); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !rsp_vld |-> !(rsp_hit || rsp_miss || rsp_pgflt || rsp_prot || rsp_dirty)); // R1
    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n) req_vld |=> (!rsp_hit || rsp_pa[PG_OFS-1:0] == $past(req_va[PG_OFS-1:0]))); // R3
    AST_NONHIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (rsp_vld && !rsp_hit) |-> (rsp_pa == '0 && !rsp_dirty)); // R3
    AST_WRITE_DIRTY: assert property (@(posedge clk) disable iff (!rst_n) (req_vld && req_kind == 2'd1) |=> (!rsp_hit || rsp_dirty)); // R8
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) flush_all ##1 req_vld |=> rsp_miss); // R10

endmodule

bind xlat_cache xlat_cache_chk #(.VA_W(VA_W), .PA_W(PA_W), .PG_OFS(PG_OFS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_vld   (req_vld),
    .req_va    (req_va),
    .req_kind  (req_kind),
    .flush_all (flush_all),
    .rsp_vld   (rsp_vld),
    .rsp_hit   (rsp_hit),
    .rsp_miss  (rsp_miss),
    .rsp_pgflt (rsp_pgflt),
    .rsp_prot  (rsp_prot),
    .rsp_dirty (rsp_dirty),
    .rsp_pa    (rsp_pa)
);

// File: tb/xlat_cache_tb_top.sv
`timescale 1ns/1ps
// Bench for xlat_cache: a vector table walked by one loop, then directed
// tests for reset, latency, set capacity, same-cycle updates and mid-run reset.
module xlat_cache_tb_top;

    localparam logic [1:0] OP_REQ = 2'd0, OP_FILL = 2'd1, OP_INV = 2'd2, OP_FLUSH = 2'd3;
    localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_EX = 2'd2;
    localparam logic [1:0] G_RO = 2'd0, G_RW = 2'd1, G_RX = 2'd2, G_RWX = 2'd3;
    localparam logic [1:0] E_MISS = 2'd0, E_HIT = 2'd1, E_PGF = 2'd2, E_PROT = 2'd3;
    localparam logic [46:0] TMAX = {47{1'b1}};
    localparam logic [46:0] TFLP = {1'b0, {46{1'b1}}};

    typedef struct packed {
        logic [3:0]  rq;
        logic [1:0]  op;
        logic [46:0] tag;
        logic [4:0]  set;
        logic [11:0] ofs;
        logic [7:0]  asid;
        logic [1:0]  kind;
        logic        prs;
        logic [19:0] frm;
        logic [1:0]  eo;
        logic        ed;
    } vec_t;

    localparam int NV = 40;
    localparam vec_t VECS [NV] = '{
        '{4'd1,  OP_REQ,   47'd5, 5'd3,  12'h123, 8'd1, K_RD,  1'b0, 20'h00000, E_MISS, 1'b0}, // R1
        '{4'd0,  OP_FILL,  47'd5, 5'd3,  12'h000, 8'd1, G_RW,  1'b1, 20'hABCDE, E_MISS, 1'b0},
        '{4'd3,  OP_REQ,   47'd5, 5'd3,  12'h123, 8'd1, K_RD,  1'b0, 20'hABCDE, E_HIT,  1'b0}, // R3
        '{4'd8,  OP_REQ,   47'd5, 5'd3,  12'h456, 8'd1, K_WR,  1'b0, 20'hABCDE, E_HIT,  1'b1}, // R8
        '{4'd8,  OP_REQ,   47'd5, 5'd3,  12'h789, 8'd1, K_RD,  1'b0, 20'hABCDE, E_HIT,  1'b1}, // R8
        '{4'd0,  OP_FILL,  47'd9, 5'd3,  12'h000, 8'd1, G_RO,  1'b1, 20'h11111, E_MISS, 1'b0},
        '{4'd7,  OP_REQ,   47'd9, 5'd3,  12'h010, 8'd1, K_WR,  1'b0, 20'h11111, E_PROT, 1'b0}, // R7
        '{4'd8,  OP_REQ,   47'd9, 5'd3,  12'h020, 8'd1, K_RD,  1'b0, 20'h11111, E_HIT,  1'b0}, // R8
        '{4'd7,  OP_REQ,   47'd9, 5'd3,  12'h030, 8'd1, K_EX,  1'b0, 20'h11111, E_PROT, 1'b0}, // R7
        '{4'd0,  OP_FILL,  47'd7, 5'd3,  12'h000, 8'd1, G_RX,  1'b1, 20'h22222, E_MISS, 1'b0},
        '{4'd7,  OP_REQ,   47'd7, 5'd3,  12'h040, 8'd1, K_EX,  1'b0, 20'h22222, E_HIT,  1'b0}, // R7
        '{4'd7,  OP_REQ,   47'd7, 5'd3,  12'h050, 8'd1, K_WR,  1'b0, 20'h22222, E_PROT, 1'b0}, // R7
        '{4'd0,  OP_FILL,  47'd2, 5'd3,  12'h000, 8'd1, G_RWX, 1'b0, 20'h0F0F0, E_MISS, 1'b0},
        '{4'd6,  OP_REQ,   47'd2, 5'd3,  12'h060, 8'd1, K_RD,  1'b0, 20'h00000, E_PGF,  1'b0}, // R6
        '{4'd11, OP_REQ,   47'd5, 5'd3,  12'h070, 8'd2, K_RD,  1'b0, 20'h00000, E_MISS, 1'b0}, // R11
        '{4'd0,  OP_FILL,  47'd5, 5'd3,  12'h000, 8'd2, G_RW,  1'b1, 20'h33333, E_MISS, 1'b0},
        '{4'd11, OP_REQ,   47'd5, 5'd3,  12'h080, 8'd2, K_RD,  1'b0, 20'h33333, E_HIT,  1'b0}, // R11
        '{4'd5,  OP_REQ,   47'd5, 5'd3,  12'h090, 8'd1, K_RD,  1'b0, 20'h00000, E_MISS, 1'b0}, // R5 way0 evicted
        '{4'd0,  OP_FILL,  47'd9, 5'd3,  12'h000, 8'd1, G_RW,  1'b1, 20'h44444, E_MISS, 1'b0},
        '{4'd5,  OP_REQ,   47'd9, 5'd3,  12'h0A0, 8'd1, K_WR,  1'b0, 20'h44444, E_HIT,  1'b1}, // R5 in place
        '{4'd0,  OP_FILL,  47'd6, 5'd3,  12'h000, 8'd1, G_RWX, 1'b1, 20'h55555, E_MISS, 1'b0},
        '{4'd5,  OP_REQ,   47'd9, 5'd3,  12'h0B0, 8'd1, K_RD,  1'b0, 20'h00000, E_MISS, 1'b0}, // R5 pointer held
        '{4'd5,  OP_REQ,   47'd7, 5'd3,  12'h0C0, 8'd1, K_EX,  1'b0, 20'h22222, E_HIT,  1'b0}, // R5
        '{4'd3,  OP_REQ,   47'd6, 5'd3,  12'hFFF, 8'd1, K_RD,  1'b0, 20'h55555, E_HIT,  1'b0}, // R3
        '{4'd0,  OP_FILL,  47'd5, 5'd4,  12'h000, 8'd1, G_RW,  1'b1, 20'h66666, E_MISS, 1'b0},
        '{4'd4,  OP_REQ,   47'd5, 5'd4,  12'h000, 8'd1, K_RD,  1'b0, 20'h66666, E_HIT,  1'b0}, // R4
        '{4'd0,  OP_INV,   47'd5, 5'd4,  12'h000, 8'd1, K_RD,  1'b0, 20'h00000, E_MISS, 1'b0},
        '{4'd9,  OP_REQ,   47'd5, 5'd4,  12'h001, 8'd1, K_RD,  1'b0, 20'h00000, E_MISS, 1'b0}, // R9
        '{4'd0,  OP_INV,   47'd7, 5'd3,  12'h000, 8'd1, K_RD,  1'b0, 20'h00000, E_MISS, 1'b0},
        '{4'd9,  OP_REQ,   47'd7, 5'd3,  12'h002, 8'd1, K_EX,  1'b0, 20'h00000, E_MISS, 1'b0}, // R9
        '{4'd9,  OP_REQ,   47'd6, 5'd3,  12'h003, 8'd1, K_RD,  1'b0, 20'h55555, E_HIT,  1'b0}, // R9
        '{4'd0,  OP_INV,   47'd5, 5'd3,  12'h000, 8'd1, K_RD,  1'b0, 20'h00000, E_MISS, 1'b0},
        '{4'd11, OP_REQ,   47'd5, 5'd3,  12'h004, 8'd2, K_RD,  1'b0, 20'h33333, E_HIT,  1'b0}, // R11
        '{4'd0,  OP_FILL,  TMAX,  5'd31, 12'h000, 8'd1, G_RW,  1'b1, 20'hFFFFF, E_MISS, 1'b0},
        '{4'd4,  OP_REQ,   TMAX,  5'd31, 12'hABC, 8'd1, K_RD,  1'b0, 20'hFFFFF, E_HIT,  1'b0}, // R4
        '{4'd4,  OP_REQ,   TFLP,  5'd31, 12'hABC, 8'd1, K_RD,  1'b0, 20'h00000, E_MISS, 1'b0}, // R4
        '{4'd4,  OP_REQ,   TMAX,  5'd30, 12'hABC, 8'd1, K_RD,  1'b0, 20'h00000, E_MISS, 1'b0}, // R4
        '{4'd0,  OP_FLUSH, 47'd0, 5'd0,  12'h000, 8'd0, K_RD,  1'b0, 20'h00000, E_MISS, 1'b0},
        '{4'd10, OP_REQ,   47'd6, 5'd3,  12'h005, 8'd1, K_RD,  1'b0, 20'h00000, E_MISS, 1'b0}, // R10
        '{4'd10, OP_REQ,   47'd5, 5'd3,  12'h006, 8'd2, K_RD,  1'b0, 20'h00000, E_MISS, 1'b0}  // R10
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_vld, fill_en, fill_prs, fill_drt, inv_en, flush_all;
    logic [63:0] req_va;
    logic [1:0]  req_kind, fill_rgt;
    logic [7:0]  req_asid, fill_asid, inv_asid;
    logic [51:0] fill_vpn, inv_vpn;
    logic [19:0] fill_frm;
    logic        rsp_vld, rsp_hit, rsp_miss, rsp_pgflt, rsp_prot, rsp_dirty;
    logic [31:0] rsp_pa;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    xlat_cache dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_vld(req_vld), .req_va(req_va), .req_kind(req_kind), .req_asid(req_asid),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_asid(fill_asid), .fill_prs(fill_prs),
        .fill_drt(fill_drt), .fill_rgt(fill_rgt), .fill_frm(fill_frm),
        .inv_en(inv_en), .inv_vpn(inv_vpn), .inv_asid(inv_asid), .flush_all(flush_all),
        .rsp_vld(rsp_vld), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_pgflt(rsp_pgflt),
        .rsp_prot(rsp_prot), .rsp_dirty(rsp_dirty), .rsp_pa(rsp_pa)
    );

    task automatic idle_inputs();
        req_vld = 1'b0; req_va = '0; req_kind = '0; req_asid = '0;
        fill_en = 1'b0; fill_vpn = '0; fill_asid = '0; fill_prs = 1'b0;
        fill_drt = 1'b0; fill_rgt = '0; fill_frm = '0;
        inv_en = 1'b0; inv_vpn = '0; inv_asid = '0; flush_all = 1'b0;
    endtask

    task automatic set_req(input logic [46:0] t, input logic [4:0] s, input logic [11:0] o,
                           input logic [7:0] a, input logic [1:0] k);
        req_vld = 1'b1; req_va = {t, s, o}; req_asid = a; req_kind = k;
    endtask

    task automatic set_fill(input logic [46:0] t, input logic [4:0] s, input logic [7:0] a,
                            input logic [1:0] g, input logic p, input logic [19:0] f);
        fill_en = 1'b1; fill_vpn = {t, s}; fill_asid = a; fill_rgt = g; fill_prs = p; fill_frm = f;
    endtask

    // Compare the registered response with the expected outcome.
    task automatic check_rsp(input string rq, input logic [1:0] eo, input logic [19:0] ef,
                             input logic [11:0] eofs, input logic ed);
        logic [4:0]  exp_f, got_f;
        logic [31:0] exp_pa;
        logic        exp_d;
        exp_f  = {1'b1, eo == E_HIT, eo == E_MISS, eo == E_PGF, eo == E_PROT};
        got_f  = {rsp_vld, rsp_hit, rsp_miss, rsp_pgflt, rsp_prot};
        exp_pa = (eo == E_HIT) ? {ef, eofs} : 32'h0;
        exp_d  = (eo == E_HIT) ? ed : 1'b0;
        n_chk++;
        if (got_f !== exp_f || rsp_pa !== exp_pa || rsp_dirty !== exp_d) begin
            n_fail++;
            $display("FAIL %s: vld/hit/miss/pgf/prot=%b pa=%h dirty=%b, expected %b pa=%h dirty=%b",
                     rq, got_f, rsp_pa, rsp_dirty, exp_f, exp_pa, exp_d);
        end
    endtask

    task automatic check_idle(input string rq);
        n_chk++;
        if ({rsp_vld, rsp_hit, rsp_miss, rsp_pgflt, rsp_prot, rsp_dirty} !== 6'b0 || rsp_pa !== 32'h0) begin
            n_fail++;
            $display("FAIL %s: flags=%b pa=%h, expected 000000 pa=00000000", rq,
                     {rsp_vld, rsp_hit, rsp_miss, rsp_pgflt, rsp_prot, rsp_dirty}, rsp_pa);
        end
    endtask

    task automatic report();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            report();
        end
    end

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 reset state");

        // Vector table walk: each entry is one cycle; lookups checked a cycle later.
        for (int i = 0; i < NV; i++) begin
            idle_inputs();
            case (VECS[i].op)
                OP_REQ:   set_req(VECS[i].tag, VECS[i].set, VECS[i].ofs, VECS[i].asid, VECS[i].kind);
                OP_FILL:  set_fill(VECS[i].tag, VECS[i].set, VECS[i].asid, VECS[i].kind, VECS[i].prs, VECS[i].frm);
                OP_INV:   begin inv_en = 1'b1; inv_vpn = {VECS[i].tag, VECS[i].set}; inv_asid = VECS[i].asid; end
                default:  flush_all = 1'b1;
            endcase
            @(negedge clk);
            idle_inputs();
            if (VECS[i].op == OP_REQ)
                check_rsp($sformatf("R%0d vector %0d", VECS[i].rq, i), VECS[i].eo, VECS[i].frm, VECS[i].ofs, VECS[i].ed);
        end

        // R2: no request gives no response.
        @(negedge clk);
        check_idle("R2 idle cycle");

        // R4: four pages share set 10.
        for (int w = 1; w <= 4; w++) begin
            set_fill(47'(w), 5'd10, 8'd1, G_RW, 1'b1, 20'(32'h1000 + w));
            @(negedge clk);
            idle_inputs();
        end
        for (int w = 1; w <= 4; w++) begin
            set_req(47'(w), 5'd10, 12'h5A5, 8'd1, K_RD);
            @(negedge clk);
            idle_inputs();
            check_rsp("R4 four ways", E_HIT, 20'(32'h1000 + w), 12'h5A5, 1'b0);
        end

        // R12: lookup beside a refill sees the old contents.
        set_fill(47'd8, 5'd12, 8'd1, G_RW, 1'b1, 20'h77777);
        set_req(47'd8, 5'd12, 12'h321, 8'd1, K_RD);
        @(negedge clk);
        idle_inputs();
        check_rsp("R12 lookup during refill", E_MISS, 20'h0, 12'h0, 1'b0);
        set_req(47'd8, 5'd12, 12'h321, 8'd1, K_RD);
        @(negedge clk);
        idle_inputs();
        check_rsp("R12 lookup after refill", E_HIT, 20'h77777, 12'h321, 1'b0);

        // R12: invalidate wins over refill of the same page in one cycle.
        set_fill(47'd8, 5'd12, 8'd1, G_RW, 1'b1, 20'h78787);
        inv_en = 1'b1; inv_vpn = {47'd8, 5'd12}; inv_asid = 8'd1;
        @(negedge clk);
        idle_inputs();
        set_req(47'd8, 5'd12, 12'h111, 8'd1, K_RD);
        @(negedge clk);
        idle_inputs();
        check_rsp("R12 invalidate over refill", E_MISS, 20'h0, 12'h0, 1'b0);

        // R12: lookup beside a flush sees the old contents; the next does not.
        flush_all = 1'b1;
        set_req(47'd2, 5'd10, 12'h00F, 8'd1, K_RD);
        @(negedge clk);
        idle_inputs();
        check_rsp("R12 lookup during flush", E_HIT, 20'h01002, 12'h00F, 1'b0);
        set_req(47'd2, 5'd10, 12'h00F, 8'd1, K_RD);
        @(negedge clk);
        idle_inputs();
        check_rsp("R10 lookup after flush", E_MISS, 20'h0, 12'h0, 1'b0);

        // R1: reset in mid-run empties the cache.
        set_fill(47'd3, 5'd20, 8'd4, G_RW, 1'b1, 20'h9ABCD);
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        set_req(47'd3, 5'd20, 12'h0, 8'd4, K_RD);
        @(negedge clk);
        idle_inputs();
        check_rsp("R1 reset clears entries", E_MISS, 20'h0, 12'h0, 1'b0);

        report();
    end

endmodule